// File: doc/BRIEF.md
# Fractional Baud Tick Generator with Deferred Divisor Update

This block derives a 16x oversampling baud tick from the system clock. The divide ratio is a 16-bit whole part plus a 6-bit fraction in sixty-fourths. The fraction is spread over time by adding it to an accumulator once per whole period. Each period in which that sum overflows lasts one extra system clock, so the average period comes out at N + F/64 cycles.

Software writes new divisor values into staged registers. They do not touch the running tick until two things have happened. First, a line-control write arms the update. Second, the character currently being sent or received finishes, which the serial engines signal by dropping a busy flag. Both the active and the staged divisors are brought out, so a test can see which values are live.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the staged and active whole and fraction divisors are all zero, and the tick is high on every cycle.
- R2: A whole or fraction write strobe loads its data into the matching staged register on that clock edge. The active divisors and the tick are unaffected until a commit.
- R3: A line-control write arms a commit. The commit takes place at the first clock edge, counting the edge of the line-control write itself, at which the busy flag is low. At that edge the active divisors take the staged values, and the period counter and the fraction accumulator clear.
- R4: While the busy flag is high an armed commit waits, and the active divisors and the tick sequence continue unchanged.
- R5: Several staged writes before one commit collapse into a single update carrying the most recent value of each field.
- R6: An active whole divisor of zero gives a divide ratio of one. The tick is high on every cycle and the fraction has no effect.
- R7: With an active whole divisor N ≥ 1 and fraction 0, the tick is a one-cycle pulse once every N cycles. The first tick comes in the Nth cycle after the commit edge.
- R8: With fraction F, each period adds F to a 6-bit accumulator that starts at zero after a commit. A period whose sum reaches 64 or more lasts N+1 cycles, and the accumulator keeps the sum modulo 64.
- R9: A staged write in the same cycle as a commit goes only into the staged register. The commit carries the staged values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| intWrEn | input | 1 | Write strobe for the staged whole divisor |
| intWrData | input | 16 | Whole divisor write data |
| fracWrEn | input | 1 | Write strobe for the staged fraction |
| fracWrData | input | 6 | Fraction write data, in units of 1/64 |
| lineCtlWr | input | 1 | Line-control write strobe that arms a commit |
| charBusy | input | 1 | High while a character is in flight |
| baudTick | output | 1 | 16x oversampling tick |
| activeInt | output | 16 | Whole divisor in use |
| activeFrac | output | 6 | Fraction in use |
| stagedInt | output | 16 | Staged whole divisor |
| stagedFrac | output | 6 | Staged fraction |

## Verification
The bench holds the busy flag high across an armed commit. A design that committed early would change the tick spacing in mid-character. It checks that the counter and accumulator restart at the commit: one that did not would give an irregular first period. It stacks several writes before one commit and writes in the very cycle of a commit. A design that latched values at write time, or took the same-cycle write, would show the wrong active value. It also drives fractions that overflow at different phases and a whole divisor of zero with a non-zero fraction. That exposes a misplaced extra cycle, or a fraction that leaks into the divide-by-one case.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int unsigned DEF_INT_W  = 16;
  localparam int unsigned DEF_FRAC_W = 6;

  typedef struct packed {
    logic commit;
    logic armed;
  } baudCtl_t;
endpackage

// File: rtl/frac_baud_ctrl.sv
module frac_baud_ctrl
  import frac_baud_pkg::*;
#(
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intWrEn,
  input  logic [INT_W-1:0]  intWrData,
  input  logic              fracWrEn,
  input  logic [FRAC_W-1:0] fracWrData,
  input  logic              lineCtlWr,
  input  logic              charBusy,
  output logic [INT_W-1:0]  stagedInt,
  output logic [FRAC_W-1:0] stagedFrac,
  output baudCtl_t          ctl
);
  logic pending;

  always_comb begin
    ctl.armed  = pending | lineCtlWr;
    ctl.commit = ctl.armed & ~charBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedInt  <= '0;
      stagedFrac <= '0;
      pending    <= 1'b0;
    end else begin
      if (intWrEn)  stagedInt  <= intWrData;
      if (fracWrEn) stagedFrac <= fracWrData;
      if (ctl.commit)     pending <= 1'b0;
      else if (lineCtlWr) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/frac_baud_dp.sv
module frac_baud_dp
  import frac_baud_pkg::*;
#(
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  baudCtl_t          ctl,
  input  logic [INT_W-1:0]  stagedInt,
  input  logic [FRAC_W-1:0] stagedFrac,
  output logic [INT_W-1:0]  activeInt,
  output logic [FRAC_W-1:0] activeFrac,
  output logic              baudTick
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  periodCnt;
  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   accSum;
  logic [CNT_W-1:0]  lastCount;
  logic              unity;

  always_comb begin
    accSum    = {1'b0, fracAcc} + {1'b0, activeFrac};
    unity     = (activeInt == '0);
    lastCount = CNT_W'(activeInt) - CNT_W'(1) + CNT_W'(accSum[FRAC_W]);
    baudTick  = unity | (periodCnt == lastCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeInt  <= '0;
      activeFrac <= '0;
      periodCnt  <= '0;
      fracAcc    <= '0;
    end else if (ctl.commit) begin
      activeInt  <= stagedInt;
      activeFrac <= stagedFrac;
      periodCnt  <= '0;
      fracAcc    <= '0;
    end else if (!unity) begin
      if (baudTick) begin
        periodCnt <= '0;
        fracAcc   <= accSum[FRAC_W-1:0];
      end else begin
        periodCnt <= periodCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intWrEn,
  input  logic [INT_W-1:0]  intWrData,
  input  logic              fracWrEn,
  input  logic [FRAC_W-1:0] fracWrData,
  input  logic              lineCtlWr,
  input  logic              charBusy,
  output logic              baudTick,
  output logic [INT_W-1:0]  activeInt,
  output logic [FRAC_W-1:0] activeFrac,
  output logic [INT_W-1:0]  stagedInt,
  output logic [FRAC_W-1:0] stagedFrac
);
  baudCtl_t ctl;

  frac_baud_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .intWrEn(intWrEn), .intWrData(intWrData),
    .fracWrEn(fracWrEn), .fracWrData(fracWrData),
    .lineCtlWr(lineCtlWr), .charBusy(charBusy),
    .stagedInt(stagedInt), .stagedFrac(stagedFrac),
    .ctl(ctl)
  );

  frac_baud_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stagedInt(stagedInt), .stagedFrac(stagedFrac),
    .activeInt(activeInt), .activeFrac(activeFrac),
    .baudTick(baudTick)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int unsigned INT_W  = 16,
  parameter int unsigned FRAC_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              intWrEn,
  input logic [INT_W-1:0]  intWrData,
  input logic              fracWrEn,
  input logic [FRAC_W-1:0] fracWrData,
  input logic              charBusy,
  input logic              baudTick,
  input logic [INT_W-1:0]  activeInt,
  input logic [FRAC_W-1:0] activeFrac,
  input logic [INT_W-1:0]  stagedInt,
  input logic [FRAC_W-1:0] stagedFrac
);
  a_r2_int_staged: assert property (@(posedge clk) disable iff (!rstN)
    intWrEn |=> stagedInt == $past(intWrData));

  a_r2_frac_staged: assert property (@(posedge clk) disable iff (!rstN)
    fracWrEn |=> stagedFrac == $past(fracWrData));

  a_r4_busy_holds_int: assert property (@(posedge clk) disable iff (!rstN)
    charBusy |=> $stable(activeInt) && $stable(activeFrac));

  a_r3_change_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeInt) |-> !$past(charBusy));

  a_r6_unity_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (activeInt == '0) |-> baudTick);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (baudTick && activeInt > INT_W'(1)) |=> (!baudTick || activeInt != $past(activeInt)));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .intWrEn(intWrEn), .intWrData(intWrData),
  .fracWrEn(fracWrEn), .fracWrData(fracWrData),
  .charBusy(charBusy), .baudTick(baudTick),
  .activeInt(activeInt), .activeFrac(activeFrac),
  .stagedInt(stagedInt), .stagedFrac(stagedFrac)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intWrEn = 1'b0;
  logic [15:0] intWrData = '0;
  logic        fracWrEn = 1'b0;
  logic [5:0]  fracWrData = '0;
  logic        lineCtlWr = 1'b0;
  logic        charBusy = 1'b0;
  logic        baudTick;
  logic [15:0] activeInt, stagedInt;
  logic [5:0]  activeFrac, stagedFrac;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  int mStInt = 0, mStFrac = 0, mActInt = 0, mActFrac = 0;
  int mCnt = 0, mAcc = 0;
  bit mPend = 0;

  always #10 clk = ~clk;

  frac_baud_gen dut_i (
    .clk(clk), .rstN(rstN),
    .intWrEn(intWrEn), .intWrData(intWrData),
    .fracWrEn(fracWrEn), .fracWrData(fracWrData),
    .lineCtlWr(lineCtlWr), .charBusy(charBusy),
    .baudTick(baudTick), .activeInt(activeInt), .activeFrac(activeFrac),
    .stagedInt(stagedInt), .stagedFrac(stagedFrac)
  );

  function automatic bit modelTick();
    int extra;
    if (mActInt == 0) return 1'b1;
    extra = ((mAcc + mActFrac) >= 64) ? 1 : 0;
    return mCnt == mActInt - 1 + extra;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mStInt = 0; mStFrac = 0; mActInt = 0; mActFrac = 0;
      mCnt = 0; mAcc = 0; mPend = 0;
    end else begin
      bit tk, cm;
      tk = modelTick();
      cm = (mPend || lineCtlWr) && !charBusy;
      if (cm) begin
        mActInt = mStInt; mActFrac = mStFrac; mCnt = 0; mAcc = 0; mPend = 0;
      end else begin
        if (lineCtlWr) mPend = 1;
        if (mActInt != 0) begin
          if (tk) begin mCnt = 0; mAcc = (mAcc + mActFrac) % 64; end
          else mCnt++;
        end
      end
      if (intWrEn)  mStInt = intWrData;
      if (fracWrEn) mStFrac = fracWrData;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("tick", int'(baudTick), int'(modelTick()));
      check("activeInt", int'(activeInt), mActInt);
      check("activeFrac", int'(activeFrac), mActFrac);
      check("stagedInt", int'(stagedInt), mStInt);
      check("stagedFrac", int'(stagedFrac), mStFrac);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrInt(int v);
    @(negedge clk); intWrEn = 1'b1; intWrData = 16'(v);
    @(negedge clk); intWrEn = 1'b0;
  endtask

  task automatic wrFrac(int v);
    @(negedge clk); fracWrEn = 1'b1; fracWrData = 6'(v);
    @(negedge clk); fracWrEn = 1'b0;
  endtask

  task automatic lineCtl();
    @(negedge clk); lineCtlWr = 1'b1;
    @(negedge clk); lineCtlWr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tag = "R1";
    check("reset tick", int'(baudTick), 1);
    check("reset activeInt", int'(activeInt), 0);
    check("reset stagedInt", int'(stagedInt), 0);
    check("reset activeFrac", int'(activeFrac), 0);

    tag = "R2";
    wrInt(5); wrFrac(0);
    check("staged R2", int'(stagedInt), 5);
    check("active unchanged R2", int'(activeInt), 0);
    idle(5);

    tag = "R7";
    lineCtl();
    idle(40);
    check("active R3", int'(activeInt), 5);

    tag = "R4";
    charBusy = 1'b1;
    wrInt(3); wrFrac(16);
    lineCtl();
    idle(12);
    check("deferred R4", int'(activeInt), 5);
    charBusy = 1'b0;
    @(negedge clk);
    check("applied R3", int'(activeInt), 3);
    tag = "R8";
    idle(60);

    tag = "R8";
    wrInt(2); wrFrac(45);
    lineCtl();
    idle(50);

    tag = "R5";
    wrInt(7); wrInt(9); wrFrac(10); wrInt(4); wrFrac(40);
    lineCtl();
    idle(2);
    check("collapse int R5", int'(activeInt), 4);
    check("collapse frac R5", int'(activeFrac), 40);
    idle(40);

    tag = "R9";
    @(negedge clk); lineCtlWr = 1'b1; intWrEn = 1'b1; intWrData = 16'd11;
    @(negedge clk); lineCtlWr = 1'b0; intWrEn = 1'b0;
    check("same-cycle active R9", int'(activeInt), 4);
    check("same-cycle staged R9", int'(stagedInt), 11);
    idle(20);

    tag = "R6";
    wrInt(0); wrFrac(33);
    lineCtl();
    idle(1);
    check("unity R6", int'(baudTick), 1);
    idle(20);

    tag = "R7";
    wrInt(1); wrFrac(0);
    lineCtl();
    idle(10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule